// File: doc/BRIEF.md
# Handshake Channel Controller

This block is a clock-sampled model of a bundled-data handshake link between a sending side and a receiving side. The sender accepts a word with a one-cycle ready strobe, places it on the channel bus and raises a request event. The receiver answers with an acknowledge event. A state-holding agreement primitive (a C-element: the output follows the two inputs when they match and holds otherwise) produces each handshake event. Every such element is forced to 0 by reset, so the link cannot start up in a deadlocked state.

A parameter selects one of two signalling modes. In transition mode each toggle of a control line is one event, and either polarity counts. The sender builds its request from one C-element fed by the inverted acknowledge. In level (return-to-zero) mode every transfer drives request and acknowledge high and then low again. The sender uses a request element and a retire element, with inverted feedback. The receiver can stall. While it stalls it holds back its acknowledge, and the sender keeps request and bus unchanged. Each accepted word appears on a receiver output register with a one-cycle valid pulse.

Top module: `hs_channel_ctrl`

## Requirements
- R1: Each C-element output takes the value of its inputs on the clock edge where they agree, and keeps its value on an edge where they differ.
- R2: While reset is low, and after it is released, `req_o`, `ack_o`, `src_busy_o` and `sink_valid_o` are 0. This holds even when reset is applied in the middle of a transfer.
- R3: In transition mode, `req_o` changes level 1 cycle after the accepting edge. `ack_o` changes level 1 cycle after that. Both rising and falling changes count as events.
- R4: In level mode a transfer runs as follows, counted from the accepting edge E0: `req_o` rises at E1, `ack_o` rises at E2, `req_o` falls at E5 and `ack_o` falls at E6. A new word can be accepted at E7.
- R5: `src_busy_o` is 1 from the cycle after an accepted strobe up to the edge of the final acknowledge event. A strobe that arrives while it is 1 is ignored and starts no transfer.
- R6: `chan_data_o` loads the strobed word on the accepting edge. It stays unchanged while `src_busy_o` is 1.
- R7: `sink_valid_o` is 1 for exactly one cycle. It is set on the same edge as an acknowledge event: any toggle in transition mode, the rising edge only in level mode. `sink_data_o` then holds the transferred word.
- R8: While `sink_stall_i` is 1, `ack_o` does not change and `req_o` and `chan_data_o` stay unchanged. The withheld acknowledge event occurs on the first edge after stall drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| src_ready_i | input | 1 | One-cycle strobe: word on src_data_i is ready |
| src_data_i | input | DATA_W | Word to send |
| sink_stall_i | input | 1 | Receiver stall: withhold acknowledge |
| src_busy_o | output | 1 | Sender has a transfer in flight |
| req_o | output | 1 | Request control line |
| ack_o | output | 1 | Acknowledge control line |
| chan_data_o | output | DATA_W | Bundled channel data bus |
| sink_valid_o | output | 1 | One-cycle pulse: new word on sink_data_o |
| sink_data_o | output | DATA_W | Word captured by the receiver |

## Verification
Counted from the edge that accepts a strobe:
- `src_busy_o` and `chan_data_o` respond at that edge.
- `req_o` responds 1 edge later.
- `ack_o`, `sink_valid_o` and `sink_data_o` respond 2 edges later in both modes.
- In level mode the return to zero completes at edges 5 and 6.
- After stall drops, the withheld acknowledge is due on the very next edge.

The bench drives inputs on the falling clock edge and samples once per falling edge. It checks every line against the expected value for that edge count, so an event arriving one cycle early or late is reported.

// File: rtl/hs_pkg.sv
package hs_pkg;
  // Signalling discipline of the channel
  typedef enum logic {
    HS_TRANSITION = 1'b0,  // every toggle is an event
    HS_LEVEL      = 1'b1   // return-to-zero sequence
  } hs_sig_e;
endpackage

// File: rtl/hs_celem.sv
module hs_celem (
  input  logic clk,
  input  logic rst_n,
  input  logic a_i,
  input  logic b_i,
  output logic q_o
);
  logic q_d;

  always_comb begin
    q_d = q_o;
    if (a_i == b_i) q_d = a_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= q_d;
  end

  assert_agree_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (a_i == b_i) |=> (q_o == $past(a_i)));
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (a_i != b_i) |=> $stable(q_o));
endmodule

// File: rtl/hs_sender.sv
module hs_sender #(
  parameter int              DATA_W = 8,
  parameter hs_pkg::hs_sig_e MODE   = hs_pkg::HS_TRANSITION
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ready_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] bus_o
);
  logic accept;
  assign accept = ready_i & ~busy_o;

  // Bundled data register, loaded only on an accepted strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_o <= '0;
    else if (accept) bus_o <= data_i;
  end

  generate
    if (MODE == hs_pkg::HS_TRANSITION) begin : g_two
      logic tok_q, tok_d, ack_n;
      assign tok_d  = tok_q ^ accept;
      assign ack_n  = ~ack_i;
      assign busy_o = tok_q ^ ack_i;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tok_q <= 1'b0;
        else        tok_q <= tok_d;
      end

      hs_celem u_req (.clk(clk), .rst_n(rst_n), .a_i(tok_q), .b_i(ack_n), .q_o(req_o));

      assert_req_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o != ack_i) |=> $stable(req_o));
    end else begin : g_four
      logic sdr_q, sdr_d, ret, ret_n;
      assign ret_n  = ~ret;
      assign sdr_d  = accept | (sdr_q & ret_n);
      assign busy_o = sdr_q | req_o | ack_i;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sdr_q <= 1'b0;
        else        sdr_q <= sdr_d;
      end

      hs_celem u_req (.clk(clk), .rst_n(rst_n), .a_i(sdr_q), .b_i(ret_n), .q_o(req_o));
      hs_celem u_ret (.clk(clk), .rst_n(rst_n), .a_i(req_o), .b_i(ack_i), .q_o(ret));

      assert_req_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> req_o);
      assert_req_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_o && ack_i) |=> !req_o);
    end
  endgenerate

  assert_bus_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(bus_o));
endmodule

// File: rtl/hs_receiver.sv
module hs_receiver #(
  parameter int              DATA_W = 8,
  parameter hs_pkg::hs_sig_e MODE   = hs_pkg::HS_TRANSITION
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [DATA_W-1:0] bus_i,
  input  logic              stall_i,
  output logic              ack_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  localparam bit LEVEL = (MODE == hs_pkg::HS_LEVEL);

  logic gate, capture;

  // Under stall the second input mirrors ack, so the element holds
  assign gate    = stall_i ? ack_o : req_i;
  assign capture = ~stall_i & (req_i ^ ack_o) & (~LEVEL | req_i);

  hs_celem u_ack (.clk(clk), .rst_n(rst_n), .a_i(req_i), .b_i(gate), .q_o(ack_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_o <= 1'b0;
    else        valid_o <= capture;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_o <= '0;
    else if (capture) data_o <= bus_i;
  end

  assert_stall_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> $stable(ack_o));
  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  assert_valid_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> !$stable(ack_o));
  assert_event_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ack_o) && (!LEVEL || ack_o)) |-> valid_o);
endmodule

// File: rtl/hs_channel_ctrl.sv
module hs_channel_ctrl #(
  parameter int              DATA_W = 8,
  parameter hs_pkg::hs_sig_e MODE   = hs_pkg::HS_TRANSITION
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_ready_i,
  input  logic [DATA_W-1:0] src_data_i,
  input  logic              sink_stall_i,
  output logic              src_busy_o,
  output logic              req_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] chan_data_o,
  output logic              sink_valid_o,
  output logic [DATA_W-1:0] sink_data_o
);
  hs_sender #(.DATA_W(DATA_W), .MODE(MODE)) u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .ready_i(src_ready_i),
    .data_i (src_data_i),
    .ack_i  (ack_o),
    .req_o  (req_o),
    .busy_o (src_busy_o),
    .bus_o  (chan_data_o)
  );

  hs_receiver #(.DATA_W(DATA_W), .MODE(MODE)) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req_o),
    .bus_i  (chan_data_o),
    .stall_i(sink_stall_i),
    .ack_o  (ack_o),
    .valid_o(sink_valid_o),
    .data_o (sink_data_o)
  );

  assert_reset_lines_R2: assert property (@(posedge clk)
    !rst_n |=> (!rst_n || $past(!rst_n)) |-> (!req_o && !ack_o && !sink_valid_o));
  assert_stall_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sink_stall_i && src_busy_o && $past(src_busy_o)) |-> $stable(chan_data_o));
endmodule

// File: tb/hs_channel_ctrl_tb_top.sv
module hs_channel_ctrl_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n;
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;

  logic         l2, s2, busy2, req2, ack2, rv2;
  logic [W-1:0] d2, bus2, rd2;
  logic         l4, s4, busy4, req4, ack4, rv4;
  logic [W-1:0] d4, bus4, rd4;
  logic         lvl2;

  always #5 clk = ~clk;

  hs_channel_ctrl #(.DATA_W(W), .MODE(hs_pkg::HS_TRANSITION)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_ready_i(l2), .src_data_i(d2), .sink_stall_i(s2),
    .src_busy_o(busy2), .req_o(req2), .ack_o(ack2), .chan_data_o(bus2),
    .sink_valid_o(rv2), .sink_data_o(rd2));

  hs_channel_ctrl #(.DATA_W(W), .MODE(hs_pkg::HS_LEVEL)) dut4_i (
    .clk(clk), .rst_n(rst_n), .src_ready_i(l4), .src_data_i(d4), .sink_stall_i(s4),
    .src_busy_o(busy4), .req_o(req4), .ack_o(ack4), .chan_data_o(bus4),
    .sink_valid_o(rv4), .sink_data_o(rd4));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic nedge();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R2", "busy2", busy2, 0); chk("R2", "req2", req2, 0);
    chk("R2", "ack2", ack2, 0);   chk("R2", "valid2", rv2, 0);
    chk("R2", "busy4", busy4, 0); chk("R2", "req4", req4, 0);
    chk("R2", "ack4", ack4, 0);   chk("R2", "valid4", rv4, 0);
  endtask

  task automatic t2_xfer(input logic [W-1:0] w);
    l2 = 1'b1; d2 = w; nedge(); l2 = 1'b0;
    chk("R5", "busy after accept", busy2, 1);
    chk("R6", "bus loaded", bus2, w);
    chk("R3", "req not yet", req2, lvl2);
    nedge();
    chk("R3", "req toggled", req2, !lvl2);
    chk("R3", "ack waits", ack2, lvl2);
    nedge();
    chk("R3", "ack toggled", ack2, !lvl2);
    chk("R7", "valid pulse", rv2, 1);
    chk("R7", "sink data", rd2, w);
    nedge();
    chk("R7", "valid one cycle", rv2, 0);
    chk("R5", "busy released", busy2, 0);
    lvl2 = !lvl2;
  endtask

  task automatic t2_ignore(input logic [W-1:0] a, input logic [W-1:0] b);
    int pulses = 0;
    l2 = 1'b1; d2 = a; nedge();
    d2 = b; nedge(); l2 = 1'b0;
    chk("R5", "bus keeps first word", bus2, a);
    nedge();
    chk("R7", "first word captured", rd2, a);
    for (int i = 0; i < 5; i++) begin
      nedge();
      if (rv2) pulses++;
    end
    chk("R5", "no second transfer", pulses, 0);
    chk("R5", "lines settled", {req2, ack2, busy2}, {!lvl2, !lvl2, 1'b0});
    chk("R5", "sink data still first", rd2, a);
    lvl2 = !lvl2;
  endtask

  task automatic t2_stall(input logic [W-1:0] w);
    s2 = 1'b1; l2 = 1'b1; d2 = w; nedge(); l2 = 1'b0;
    nedge();
    for (int i = 0; i < 4; i++) begin
      nedge();
      chk("R8", "ack withheld", ack2, lvl2);
      chk("R8", "req held", req2, !lvl2);
      chk("R8", "bus held", bus2, w);
      chk("R8", "no valid", rv2, 0);
    end
    s2 = 1'b0; nedge();
    chk("R8", "ack after release", ack2, !lvl2);
    chk("R7", "valid after release", rv2, 1);
    chk("R7", "data after release", rd2, w);
    nedge();
    chk("R5", "busy off", busy2, 0);
    lvl2 = !lvl2;
  endtask

  task automatic t2_reset_mid(input logic [W-1:0] w);
    l2 = 1'b1; d2 = w; nedge(); l2 = 1'b0; nedge();
    rst_n = 1'b0; nedge();
    t_reset();
    rst_n = 1'b1; lvl2 = 1'b0; nedge();
    t_reset();
  endtask

  task automatic t4_xfer(input logic [W-1:0] w, input bit extra);
    l4 = 1'b1; d4 = w; nedge(); l4 = 1'b0;
    chk("R4", "E0 busy", busy4, 1); chk("R4", "E0 req", req4, 0); chk("R6", "E0 bus", bus4, w);
    nedge(); chk("R4", "E1 req up", req4, 1); chk("R4", "E1 ack", ack4, 0);
    nedge(); chk("R4", "E2 ack up", ack4, 1); chk("R7", "E2 valid", rv4, 1); chk("R7", "E2 data", rd4, w);
    if (extra) begin l4 = 1'b1; d4 = ~w; end
    nedge(); l4 = 1'b0;
    chk("R4", "E3 req", req4, 1); chk("R7", "E3 valid low", rv4, 0);
    nedge(); chk("R4", "E4 req", req4, 1); chk("R4", "E4 ack", ack4, 1);
    nedge(); chk("R4", "E5 req down", req4, 0); chk("R4", "E5 ack", ack4, 1);
    chk("R6", "E5 bus", bus4, w);
    nedge(); chk("R4", "E6 ack down", ack4, 0); chk("R5", "E6 busy off", busy4, 0);
    chk("R7", "no valid on falling ack", rv4, 0);
  endtask

  task automatic t4_stall(input logic [W-1:0] w);
    s4 = 1'b1; l4 = 1'b1; d4 = w; nedge(); l4 = 1'b0; nedge();
    for (int i = 0; i < 4; i++) begin
      nedge();
      chk("R8", "4p ack withheld", ack4, 0);
      chk("R8", "4p req held", req4, 1);
      chk("R8", "4p bus held", bus4, w);
    end
    s4 = 1'b0; nedge();
    chk("R8", "4p ack after release", ack4, 1);
    chk("R7", "4p valid after release", rv4, 1);
    for (int i = 0; i < 5; i++) nedge();
    chk("R4", "4p back to zero", {req4, ack4, busy4}, 3'b000);
  endtask

  initial begin
    rst_n = 1'b0; l2 = 0; s2 = 0; d2 = '0; l4 = 0; s4 = 0; d4 = '0; lvl2 = 1'b0;
    repeat (3) nedge();
    t_reset();
    rst_n = 1'b1; nedge();
    t_reset();
    t2_xfer(8'hA5);
    t2_xfer(8'h3C);
    t2_xfer(8'hFF);
    t2_ignore(8'h11, 8'h22);
    t2_stall(8'h5A);
    t2_reset_mid(8'h77);
    t2_xfer(8'h81);
    t4_xfer(8'hC3, 1'b0);
    t4_xfer(8'h0F, 1'b0);
    t4_xfer(8'h96, 1'b1);
    for (int i = 0; i < 3; i++) begin
      nedge();
      chk("R5", "4p ignored strobe", {req4, busy4}, 2'b00);
    end
    t4_stall(8'h42);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule